// File: doc/BRIEF.md
# Multi-speed I2C SCL generator

This block produces the serial clock of an I2C controller from the system clock. Three pairs of high-time and low-time counts, one each for standard, fast and high speed, are held outside the block. A two-bit speed field picks the pair that is used. The counts are in system clock cycles. Fast mode and fast-mode-plus share one pair and differ only in the values loaded into it.

A byte engine asks for clocking with a start request. It ends the clock cleanly with a stop request, or drops it at once with an idle request. The block drives an open-drain pull-down for SCL and reads the wired line back through a synchroniser. A slave that holds SCL low therefore lengthens the low phase. Four single-cycle phase strobes mark points in each SCL period so that the data path can launch and sample SDA: fall, mid-low, rise and mid-high.

When high speed is selected but the build has no high-speed capability, the block runs on the fast pair. It also uses the fast pair when either high-speed count is zero. Counts are captured only while the block is disabled.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, and whenever the generator is idle, `scl_drive_low` is 0 and all four strobes are 0.
- R2: `speed_sel` value 1 selects the standard pair and value 3 selects the high-speed pair. Values 0 and 2 select the fast pair.
- R3: With `speed_sel` = 3, the fast pair is used if `HS_CAPABLE` is 0, if `hs_high_cnt` is 0, or if `hs_low_cnt` is 0.
- R4: A selected count below `MIN_CNT` (default 6) is used as `MIN_CNT`.
- R5: The line is driven low for exactly L cycles, where L is the effective low count, and then released. The line stays high for SYNC_STAGES+1+H cycles after it is seen high, where H is the effective high count, and the next low phase follows.
- R6: A slave holding SCL low past the low count extends the low phase. High-phase timing begins only once the line has risen.
- R7: `fall_stb` is high in the first low cycle. `mid_low_stb` is high L>>1 cycles later. `rise_stb` is high in the first counted high cycle. `mid_high_stb` is high H>>1 cycles after `rise_stb`. Each strobe lasts one cycle.
- R8: A start request while idle and enabled starts driving SCL low on the next cycle, with `fall_stb` high in that cycle.
- R9: A stop request during clocking, including one in the final high cycle, lets the current high phase finish. The block then returns to idle with SCL released, and no further low phase follows.
- R10: An idle request, or `enable` low, returns the block to idle and releases SCL on the next cycle. An idle request in the same cycle as a start request wins, and no clocking starts.
- R11: The count and speed inputs are captured only while `enable` is low. Changes to them while enabled do not affect the SCL timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator enable; while low, the timing inputs are captured |
| speed_sel | input | 2 | Speed select: 1 standard, 3 high, other values fast |
| std_high_cnt | input | CNT_W | Standard-speed SCL high count |
| std_low_cnt | input | CNT_W | Standard-speed SCL low count |
| fast_high_cnt | input | CNT_W | Fast / fast-plus SCL high count |
| fast_low_cnt | input | CNT_W | Fast / fast-plus SCL low count |
| hs_high_cnt | input | CNT_W | High-speed SCL high count |
| hs_low_cnt | input | CNT_W | High-speed SCL low count |
| start_req | input | 1 | Begin clocking (one-cycle pulse) |
| stop_req | input | 1 | Finish the current high phase, then idle |
| idle_req | input | 1 | Abort clocking immediately |
| scl_in | input | 1 | Sampled state of the wired SCL line |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| fall_stb | output | 1 | First cycle of the low phase |
| mid_low_stb | output | 1 | Middle of the low phase |
| rise_stb | output | 1 | First counted high cycle |
| mid_high_stb | output | 1 | Middle of the counted high phase |

## Verification
A stop request can land in the very cycle in which the high count expires, the same cycle in which the generator would begin the next low phase. The bench waits for `rise_stb`, counts H-1 further cycles and pulses `stop_req` at that point. It then judges that SCL stays released and that no `fall_stb` appears over a long window. An idle request is also raised in the same cycle as a start request, and the bench checks that the line is never pulled low.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_LOW     = 2'd1,
      PH_WAIT_HI = 2'd2,
      PH_HIGH    = 2'd3
   } scl_phase_e;

   localparam logic [1:0] SPD_STD  = 2'd1;
   localparam logic [1:0] SPD_FAST = 2'd2;
   localparam logic [1:0] SPD_HIGH = 2'd3;

endpackage

// File: rtl/scl_timing_sel.sv
module scl_timing_sel
   import i2c_scl_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int MIN_CNT    = 6,
   parameter bit HS_CAPABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [1:0]       speed_sel,
   input  logic [CNT_W-1:0] std_high_cnt,
   input  logic [CNT_W-1:0] std_low_cnt,
   input  logic [CNT_W-1:0] fast_high_cnt,
   input  logic [CNT_W-1:0] fast_low_cnt,
   input  logic [CNT_W-1:0] hs_high_cnt,
   input  logic [CNT_W-1:0] hs_low_cnt,
   output logic [CNT_W-1:0] hi_cnt,
   output logic [CNT_W-1:0] lo_cnt
);

   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

   logic             hs_ok;
   logic [CNT_W-1:0] pick_hi, pick_lo;
   logic [CNT_W-1:0] clamp_hi, clamp_lo;
   logic [CNT_W-1:0] hi_q, lo_q;

   generate
      if (HS_CAPABLE) begin : g_hs_present
         assign hs_ok = (speed_sel == SPD_HIGH) && (hs_high_cnt != '0) && (hs_low_cnt != '0);
      end else begin : g_hs_absent
         assign hs_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      if (speed_sel == SPD_STD) begin
         pick_hi = std_high_cnt;
         pick_lo = std_low_cnt;
      end else if (hs_ok) begin
         pick_hi = hs_high_cnt;
         pick_lo = hs_low_cnt;
      end else begin
         pick_hi = fast_high_cnt;
         pick_lo = fast_low_cnt;
      end
      clamp_hi = (pick_hi < FLOOR) ? FLOOR : pick_hi;
      clamp_lo = (pick_lo < FLOOR) ? FLOOR : pick_lo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= FLOOR;
         lo_q <= FLOOR;
      end else if (!enable) begin
         hi_q <= clamp_hi;
         lo_q <= clamp_lo;
      end
   end

   assign hi_cnt = hi_q;
   assign lo_cnt = lo_q;

   // R4
   clamp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_q >= FLOOR) && (lo_q >= FLOOR))
      else $error("effective count below floor");

   // R11
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> ($stable(hi_q) && $stable(lo_q)))
      else $error("timing changed while enabled");

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= line_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_i};
         end
      end
   endgenerate

   assign line_o = chain_q[STAGES-1];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import i2c_scl_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             idle_req,
   input  logic             scl_sync,
   input  logic [CNT_W-1:0] hi_cnt,
   input  logic [CNT_W-1:0] lo_cnt,
   output logic             scl_drive_low,
   output logic             fall_stb,
   output logic             mid_low_stb,
   output logic             rise_stb,
   output logic             mid_high_stb
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   scl_phase_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             stop_q, stop_d;
   logic             abort, low_done, high_done, stop_now;

   assign abort     = !enable || idle_req;
   assign low_done  = (cnt_q == lo_cnt - ONE);
   assign high_done = (cnt_q == hi_cnt - ONE);
   assign stop_now  = stop_q || stop_req;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      stop_d  = stop_q || (stop_req && (state_q != PH_IDLE));
      case (state_q)
         PH_IDLE: begin
            cnt_d  = '0;
            stop_d = 1'b0;
            if (start_req) state_d = PH_LOW;
         end
         PH_LOW: begin
            if (low_done) begin
               state_d = PH_WAIT_HI;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end
         PH_WAIT_HI: begin
            cnt_d = '0;
            if (scl_sync) state_d = PH_HIGH;
         end
         default: begin
            if (high_done) begin
               cnt_d   = '0;
               state_d = stop_now ? PH_IDLE : PH_LOW;
               if (stop_now) stop_d = 1'b0;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end
      endcase
      if (abort) begin
         state_d = PH_IDLE;
         cnt_d   = '0;
         stop_d  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         cnt_q   <= '0;
         stop_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         stop_q  <= stop_d;
      end
   end

   assign scl_drive_low = (state_q == PH_LOW);
   assign fall_stb      = (state_q == PH_LOW)  && (cnt_q == '0);
   assign mid_low_stb   = (state_q == PH_LOW)  && (cnt_q == (lo_cnt >> 1));
   assign rise_stb      = (state_q == PH_HIGH) && (cnt_q == '0);
   assign mid_high_stb  = (state_q == PH_HIGH) && (cnt_q == (hi_cnt >> 1));

   // R10
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !scl_drive_low)
      else $error("SCL still driven after abort");

   // R8
   start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IDLE && start_req && !abort) |=> (fall_stb && scl_drive_low))
      else $error("start did not pull SCL low");

   // R6
   stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_WAIT_HI && !scl_sync && enable && !idle_req) |=> !rise_stb)
      else $error("high phase began while line low");

   // R5
   low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_drive_low |-> (cnt_q < lo_cnt))
      else $error("low phase overran its count");

   // R9
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_HIGH && high_done && (stop_req || stop_q)) |=> !scl_drive_low)
      else $error("clocking continued after stop");

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fall_stb, mid_low_stb, rise_stb, mid_high_stb}))
      else $error("phase strobes overlap");

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
   parameter int CNT_W       = 16,
   parameter int MIN_CNT     = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit HS_CAPABLE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [1:0]       speed_sel,
   input  logic [CNT_W-1:0] std_high_cnt,
   input  logic [CNT_W-1:0] std_low_cnt,
   input  logic [CNT_W-1:0] fast_high_cnt,
   input  logic [CNT_W-1:0] fast_low_cnt,
   input  logic [CNT_W-1:0] hs_high_cnt,
   input  logic [CNT_W-1:0] hs_low_cnt,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             idle_req,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             fall_stb,
   output logic             mid_low_stb,
   output logic             rise_stb,
   output logic             mid_high_stb
);

   localparam int FLOOR_BITS = $clog2(MIN_CNT + 1);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES >= MIN_CNT) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1 and below MIN_CNT");
      end
      if (MIN_CNT < 4 || CNT_W < FLOOR_BITS) begin : g_bad_floor
         $error("MIN_CNT must be at least 4 and fit in CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] hi_eff, lo_eff;
   logic             scl_sync;

   scl_timing_sel #(
      .CNT_W      (CNT_W),
      .MIN_CNT    (MIN_CNT),
      .HS_CAPABLE (HS_CAPABLE)
   ) u_sel (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .speed_sel     (speed_sel),
      .std_high_cnt  (std_high_cnt),
      .std_low_cnt   (std_low_cnt),
      .fast_high_cnt (fast_high_cnt),
      .fast_low_cnt  (fast_low_cnt),
      .hs_high_cnt   (hs_high_cnt),
      .hs_low_cnt    (hs_low_cnt),
      .hi_cnt        (hi_eff),
      .lo_cnt        (lo_eff)
   );

   scl_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (scl_in),
      .line_o (scl_sync)
   );

   scl_phase_fsm #(
      .CNT_W (CNT_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .start_req     (start_req),
      .stop_req      (stop_req),
      .idle_req      (idle_req),
      .scl_sync      (scl_sync),
      .hi_cnt        (hi_eff),
      .lo_cnt        (lo_eff),
      .scl_drive_low (scl_drive_low),
      .fall_stb      (fall_stb),
      .mid_low_stb   (mid_low_stb),
      .rise_stb      (rise_stb),
      .mid_high_stb  (mid_high_stb)
   );

endmodule

// File: tb/tb_i2c_scl_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_gen;

   localparam int CW = 16;
   localparam int SY = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0, enable = 1'b0;
   logic       start_req = 1'b0, stop_req = 1'b0, idle_req = 1'b0;
   logic       hold = 1'b0, use2 = 1'b0;
   logic [1:0] spd = 2'd2;
   int sh = 10, sl = 10, fh = 10, fl = 10, hh = 10, hl = 10;
   int n_chk = 0, n_fail = 0;

   logic d1_drv, d1_fall, d1_ml, d1_rise, d1_mh;
   logic d2_drv, d2_fall, d2_ml, d2_rise, d2_mh;
   wire  scl1 = !d1_drv && !hold;
   wire  scl2 = !d2_drv && !hold;

   i2c_scl_gen #(.CNT_W(CW), .SYNC_STAGES(SY), .HS_CAPABLE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(spd),
      .std_high_cnt(CW'(sh)), .std_low_cnt(CW'(sl)),
      .fast_high_cnt(CW'(fh)), .fast_low_cnt(CW'(fl)),
      .hs_high_cnt(CW'(hh)), .hs_low_cnt(CW'(hl)),
      .start_req(start_req), .stop_req(stop_req), .idle_req(idle_req),
      .scl_in(scl1), .scl_drive_low(d1_drv), .fall_stb(d1_fall),
      .mid_low_stb(d1_ml), .rise_stb(d1_rise), .mid_high_stb(d1_mh));

   i2c_scl_gen #(.CNT_W(CW), .SYNC_STAGES(SY), .HS_CAPABLE(1'b0)) dut_nohs (
      .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(spd),
      .std_high_cnt(CW'(sh)), .std_low_cnt(CW'(sl)),
      .fast_high_cnt(CW'(fh)), .fast_low_cnt(CW'(fl)),
      .hs_high_cnt(CW'(hh)), .hs_low_cnt(CW'(hl)),
      .start_req(start_req), .stop_req(stop_req), .idle_req(idle_req),
      .scl_in(scl2), .scl_drive_low(d2_drv), .fall_stb(d2_fall),
      .mid_low_stb(d2_ml), .rise_stb(d2_rise), .mid_high_stb(d2_mh));

   wire m_drv  = use2 ? d2_drv  : d1_drv;
   wire m_fall = use2 ? d2_fall : d1_fall;
   wire m_ml   = use2 ? d2_ml   : d1_ml;
   wire m_rise = use2 ? d2_rise : d1_rise;
   wire m_mh   = use2 ? d2_mh   : d1_mh;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic int flr(input int v);
      return (v < 6) ? 6 : v;
   endfunction

   function automatic void exp_pair(input logic [1:0] s, input bit cap,
                                    output int h, output int l);
      if (s == 2'd1) begin h = sh; l = sl; end
      else if (s == 2'd3 && cap && hh != 0 && hl != 0) begin h = hh; l = hl; end
      else begin h = fh; l = fl; end
      h = flr(h);
      l = flr(l);
   endfunction

   // expects to be called at a negedge where fall_stb is (or soon will be) high
   task automatic measure(input int stretch, output int lo_n, output int hi_n,
                          output int ml, output int rs, output int mh);
      int guard;
      lo_n = 0; hi_n = 0; ml = -1; rs = -1; mh = -1; guard = 0;
      while (!m_fall && guard < 4000) begin @(negedge clk); guard++; end
      hold = (stretch > 0);
      forever begin
         if (hold && lo_n >= stretch) hold = 1'b0;
         if (!m_drv && !hold) break;
         if (m_ml) ml = lo_n;
         lo_n++;
         @(negedge clk);
         if (lo_n > 4000) break;
      end
      forever begin
         if (m_drv) break;
         if (m_rise) rs = hi_n;
         if (m_mh) mh = hi_n;
         hi_n++;
         @(negedge clk);
         if (hi_n > 4000) break;
      end
   endtask

   task automatic do_period(input int stretch, input int h, input int l, input string rq);
      int lo_n, hi_n, ml, rs, mh;
      measure(stretch, lo_n, hi_n, ml, rs, mh);
      chk({rq, " low length"}, lo_n, (stretch > l) ? stretch : l);
      chk({rq, " high length"}, hi_n, SY + 1 + h);
      chk("R7 mid-low offset", ml, l >> 1);
      chk("R7 rise offset", rs, SY + 1);
      chk("R7 mid-high offset", mh, SY + 1 + (h >> 1));
   endtask

   task automatic setup(input logic [1:0] s, input int a, input int b, input int c,
                        input int d, input int e, input int f);
      enable = 1'b0;
      spd = s; sh = a; sl = b; fh = c; fl = d; hh = e; hl = f;
      repeat (2) @(negedge clk);
      enable = 1'b1;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      chk("R8 fall strobe after start", int'(m_fall && m_drv), 1);
   endtask

   task automatic go_idle();
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0;
      chk("R10 released after idle request", int'(m_drv), 0);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      int h, l, falls, rises, drv_seen;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset drive", int'(d1_drv), 0);
      chk("R1 reset strobes", int'(d1_fall | d1_ml | d1_rise | d1_mh), 0);

      // R2 standard pair, R5/R7 phase timing
      setup(2'd1, 10, 14, 7, 9, 8, 8);
      exp_pair(2'd1, 1'b1, h, l);
      do_period(0, h, l, "R2 std");
      do_period(0, h, l, "R5 std");
      go_idle();
      // R1 idle: no activity afterwards
      falls = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); falls += int'(m_fall | m_drv); end
      chk("R1 idle quiet", falls, 0);

      // R2 fast pair through codes 2 and 0, high pair through 3
      setup(2'd2, 10, 14, 7, 9, 8, 11);
      exp_pair(2'd2, 1'b1, h, l);
      do_period(0, h, l, "R2 fast code2");
      go_idle();
      setup(2'd0, 10, 14, 12, 7, 8, 11);
      exp_pair(2'd0, 1'b1, h, l);
      do_period(0, h, l, "R2 fast code0");
      go_idle();
      setup(2'd3, 10, 14, 12, 7, 8, 11);
      exp_pair(2'd3, 1'b1, h, l);
      do_period(0, h, l, "R2 high");
      go_idle();

      // R3 high speed with a zero count falls back to fast
      setup(2'd3, 10, 14, 12, 7, 0, 11);
      do_period(0, 12, 7, "R3 zero hs count");
      go_idle();
      // R3 build without high-speed capability
      use2 = 1'b1;
      setup(2'd3, 10, 14, 12, 7, 8, 11);
      do_period(0, 12, 7, "R3 no capability");
      go_idle();
      use2 = 1'b0;

      // R4 counts below the floor
      setup(2'd2, 10, 14, 2, 0, 8, 8);
      do_period(0, 6, 6, "R4 clamp");
      go_idle();

      // R6 slave stretches the low phase
      setup(2'd2, 10, 14, 9, 8, 8, 8);
      do_period(30, 9, 8, "R6 stretch");
      do_period(0, 9, 8, "R6 after stretch");
      go_idle();

      // R11 inputs changed while enabled have no effect
      setup(2'd1, 11, 13, 7, 9, 8, 8);
      sl = 50; sh = 40; spd = 2'd2;
      do_period(0, 11, 13, "R11 ignored while enabled");
      go_idle();

      // R9 stop during the low phase
      setup(2'd2, 10, 14, 9, 8, 8, 8);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      falls = 0; rises = 0; drv_seen = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         falls += int'(m_fall);
         rises += int'(m_rise);
      end
      drv_seen = int'(m_drv);
      chk("R9 stop: high phase completed", rises, 1);
      chk("R9 stop: no further fall", falls, 0);
      chk("R9 stop: line released", drv_seen, 0);

      // R9 stop arriving in the last high cycle
      setup(2'd2, 10, 14, 9, 8, 8, 8);
      for (int g = 0; g < 200 && !m_rise; g++) @(negedge clk);
      repeat (9 - 1) @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      falls = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); falls += int'(m_fall | m_drv); end
      chk("R9 stop in final high cycle", falls, 0);

      // R10 idle and start in the same cycle
      enable = 1'b1;
      idle_req = 1'b1; start_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0; start_req = 1'b0;
      falls = 0;
      for (int i = 0; i < 20; i++) begin falls += int'(m_fall | m_drv); @(negedge clk); end
      chk("R10 idle wins over start", falls, 0);

      // R10 disable while clocking
      setup(2'd1, 10, 14, 9, 8, 8, 8);
      enable = 1'b0;
      @(negedge clk);
      chk("R10 released on disable", int'(m_drv), 0);

      // random configurations
      for (int i = 0; i < 8; i++) begin
         logic [1:0] s;
         int st;
         s = 2'($urandom_range(0, 3));
         setup(s, $urandom_range(0, 30), $urandom_range(0, 30), $urandom_range(0, 30),
               $urandom_range(0, 30), $urandom_range(0, 30), $urandom_range(0, 30));
         exp_pair(s, 1'b1, h, l);
         st = $urandom_range(0, 40);
         do_period(0, h, l, "R5 random");
         do_period(st, h, l, "R6 random");
         go_idle();
      end

      report();
      $finish;
   end

endmodule